// File: doc/BRIEF.md
# Column Burst Address Generator

This block walks the column addresses of a single read or write burst for a four-bank double-data-rate memory, whether in a memory model or in a controller. A start pulse carries the first column, a two-bit length code and an ordering select. From the cycle after the pulse, the block presents one column per cycle, which is one data beat. Alongside each column it gives a valid flag, and it raises a last flag on the final beat of a fixed-length burst.

Short bursts of 2, 4 or 8 beats stay inside their aligned block of columns. They follow either a wrapping count or an XOR ordering. A full-page burst counts through all 256 columns, wrapping from 255 to 0, and runs until a terminate pulse arrives. Two full-page requests are refused: one with XOR ordering and one with an odd first column. A refused request raises a one-cycle error flag and starts nothing. In the two-beat prefetch, bit 0 of the start column picks which half of the column pair comes out first.

Top module: `col_burst_agen`

## Requirements
- R1: The length code sets the beat count: 2'b00 gives 2 beats, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives a full page. After a legal start, valid_o is high from the next cycle for exactly that many cycles, unless the burst is cut short.
- R2: With ilv_i = 0 (sequential), the first column equals the start column. Each later beat adds one inside the low log2(BL) bits, wrapping in the aligned block, while the upper bits stay fixed. A 2-beat burst from column 5 therefore gives 5 then 4.
- R3: With ilv_i = 1 (interleaved), beat n presents the start column XOR n, applied to the low log2(BL) bits.
- R4: A full-page request with ilv_i = 1 is refused. err_o is high in the next cycle only, no burst starts, and any burst already running goes on unchanged.
- R5: A full-page request with an odd start column is refused in the same way as R4.
- R6: A full-page burst counts up by one per beat, wraps from 255 to 0, never raises last_o, and runs until term_i.
- R7: last_o is high on the final beat of a 2, 4 or 8 beat burst, and valid_o is low in the following cycle.
- R8: When term_i is high in a cycle with valid_o high, valid_o is low from the next cycle.
- R9: A legal start during a running burst drops that burst and begins the new one at once.
- R10: While reset is held, col_o, valid_o, last_o and err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request pulse |
| term_i | input | 1 | Ends the running burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 2 | Length code (00:2, 01:4, 10:8, 11:page) |
| ilv_i | input | 1 | 0 sequential, 1 interleaved |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Previous cycle's request was refused |

## Verification
Directed bursts are aimed at the cases that set the orderings apart. An odd start in a 2-beat burst and a start near the end of a 4-beat block tell wrapping apart from plain incrementing. An 8-beat interleaved burst from column 6 separates XOR ordering from a wrapping count. A full-page burst from 254 proves the wrap to zero. Random requests with mixed lengths, orderings, terminates and restarts, some of them illegal full-page ones, then show that refused requests leave a running burst untouched and that restarts and terminates take effect in the correct cycle.

// File: rtl/colburst_pkg.sv
package colburst_pkg;
  typedef enum logic [1:0] {
    BL_2    = 2'b00,
    BL_4    = 2'b01,
    BL_8    = 2'b10,
    BL_PAGE = 2'b11
  } burst_len_e;
endpackage

// File: rtl/col_addr_calc.sv
module col_addr_calc
  import colburst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_len_e       len_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;
  logic [COL_W-1:0] sum;

  genvar i;
  generate
    for (i = 0; i < COL_W; i++) begin : g_mask
      assign mask[i] = (len_i == BL_PAGE) ||
                       (32'(i) < ({30'd0, len_i} + 32'd1));
    end
  endgenerate

  assign sum     = base_i + beat_i;
  assign seq_col = (base_i & ~mask) | (sum & mask);
  assign ilv_col = base_i ^ (beat_i & mask);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/burst_req_check.sv
module burst_req_check
  import colburst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_len_e       len_i,
  input  logic             ilv_i,
  output logic             go_o,
  output logic             bad_o
);
  logic refuse;
  assign refuse = (len_i == BL_PAGE) && (ilv_i || start_col_i[0]);
  assign go_o   = start_i && !refuse;
  assign bad_o  = start_i && refuse;
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import colburst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic             bad_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_len_e       len_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] calc_col_i,
  output logic [COL_W-1:0] calc_base_o,
  output logic [COL_W-1:0] calc_beat_o,
  output burst_len_e       calc_len_o,
  output logic             calc_ilv_o,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  burst_len_e       len_q;
  logic             ilv_q;
  logic [COL_W-1:0] last_beat;
  logic             last_nx;
  logic             stop;

  assign calc_base_o = go_i ? start_col_i : base_q;
  assign calc_beat_o = go_i ? '0 : beat_q + 1'b1;
  assign calc_len_o  = go_i ? len_i : len_q;
  assign calc_ilv_o  = go_i ? ilv_i : ilv_q;

  assign last_beat = (COL_W'(2) << calc_len_o) - 1'b1;
  assign last_nx   = (calc_len_o != BL_PAGE) && (calc_beat_o == last_beat);
  assign stop      = valid_o && (term_i || last_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      len_q   <= BL_2;
      ilv_q   <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= bad_i;
      if (go_i) begin
        base_q  <= start_col_i;
        len_q   <= len_i;
        ilv_q   <= ilv_i;
        beat_q  <= '0;
        col_o   <= calc_col_i;
        valid_o <= 1'b1;
        last_o  <= last_nx;
      end else if (stop) begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else if (valid_o) begin
        beat_q <= calc_beat_o;
        col_o  <= calc_col_i;
        last_o <= last_nx;
      end
    end
  end
endmodule

// File: rtl/col_burst_agen.sv
module col_burst_agen
  import colburst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  burst_len_e       len_in;
  burst_len_e       calc_len;
  logic             go;
  logic             bad;
  logic [COL_W-1:0] calc_base;
  logic [COL_W-1:0] calc_beat;
  logic [COL_W-1:0] calc_col;
  logic             calc_ilv;

  assign len_in = burst_len_e'(len_code_i);

  burst_req_check #(.COL_W(COL_W)) u_check (
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_i       (len_in),
    .ilv_i       (ilv_i),
    .go_o        (go),
    .bad_o       (bad)
  );

  col_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i (calc_base),
    .beat_i (calc_beat),
    .len_i  (calc_len),
    .ilv_i  (calc_ilv),
    .col_o  (calc_col)
  );

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .bad_i       (bad),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .len_i       (len_in),
    .ilv_i       (ilv_i),
    .calc_col_i  (calc_col),
    .calc_base_o (calc_base),
    .calc_beat_o (calc_beat),
    .calc_len_o  (calc_len),
    .calc_ilv_o  (calc_ilv),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/col_burst_agen_chk.sv
module col_burst_agen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [1:0]       len_code_i,
  input logic             ilv_i,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);
  assert_last_has_valid_R7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  assert_drop_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  assert_term_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> !valid_o);

  assert_err_only_page_R4: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(start_i) && $past(len_code_i) == 2'b11));

  assert_odd_page_no_burst_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i == 2'b11 && start_col_i[0] && !valid_o) |=> !valid_o);

  assert_burst_continues_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !term_i) |=> valid_o);
endmodule

bind col_burst_agen col_burst_agen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .term_i      (term_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .ilv_i       (ilv_i),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .err_o       (err_o)
);

// File: tb/tb_col_burst_agen.sv
module tb_col_burst_agen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [1:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_col = '0, m_base = '0;
  int         m_beat = 0;
  logic [1:0] m_len = '0;
  logic       m_ilv = 1'b0, m_valid = 1'b0, m_last = 1'b0, m_err = 1'b0;
  string      vtag = "R1", ctag = "R2", etag = "R4";

  always #10 clk = ~clk;

  col_burst_agen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .term_i(term_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  function automatic int burst_len(input logic [1:0] l);
    return (l == 2'b11) ? 256 : (2 << l);
  endfunction

  function automatic logic [7:0] ref_col(input logic [7:0] base, input int beat,
                                         input logic [1:0] l, input logic il);
    int bl, off, blk;
    bl  = burst_len(l);
    off = int'(base) % bl;
    blk = int'(base) - off;
    if (il) return 8'(int'(base) ^ (beat % bl));
    return 8'(blk + ((off + beat) % bl));
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic s, input logic t, input logic [7:0] c,
                     input logic [1:0] l, input logic il);
    logic legal;
    @(negedge clk);
    check(vtag, int'(valid_o), int'(m_valid));
    if (m_valid) check(ctag, int'(col_o), int'(m_col));
    check("R7", int'(last_o), int'(m_last));
    check(etag, int'(err_o), int'(m_err));
    start_i = s; term_i = t; start_col_i = c; len_code_i = l; ilv_i = il;
    legal = !(l == 2'b11 && (il || c[0]));
    vtag = "R1";
    etag = (s && l == 2'b11 && !il && c[0]) ? "R5" : "R4";
    if (s && legal) begin
      ctag   = m_valid ? "R9" : (l == 2'b11) ? "R6" : il ? "R3" : "R2";
      m_base = c; m_len = l; m_ilv = il; m_beat = 0;
      m_col  = ref_col(c, 0, l, il);
      m_valid = 1'b1; m_last = 1'b0;
    end else if (m_valid && (t || m_last)) begin
      if (t) vtag = "R8";
      m_valid = 1'b0; m_last = 1'b0;
    end else if (m_valid) begin
      if (ctag == "R9") ctag = (m_len == 2'b11) ? "R6" : m_ilv ? "R3" : "R2";
      m_beat = (m_beat + 1) % 256;
      m_col  = ref_col(m_base, m_beat, m_len, m_ilv);
      m_last = (m_len != 2'b11) && (m_beat == burst_len(m_len) - 1);
    end
    m_err = s && !legal;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 2'b00, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic s, t, il;
    logic [7:0] c;
    logic [1:0] l;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", int'(col_o), 0);
    check("R10", int'(valid_o), 0);
    check("R10", int'(last_o), 0);
    check("R10", int'(err_o), 0);
    rst = 1'b0;
    // R2: two-beat burst from an odd column: 5 then 4
    cyc(1'b1, 1'b0, 8'd5, 2'b00, 1'b0); idle(3);
    // R2: four-beat wrap 1E,1F,1C,1D
    cyc(1'b1, 1'b0, 8'h1E, 2'b01, 1'b0); idle(5);
    // R3: eight-beat interleaved from 6
    cyc(1'b1, 1'b0, 8'd6, 2'b10, 1'b1); idle(9);
    cyc(1'b1, 1'b0, 8'd9, 2'b01, 1'b1); idle(5);
    // R4 / R5: refused full-page requests
    cyc(1'b1, 1'b0, 8'h10, 2'b11, 1'b1); idle(2);
    cyc(1'b1, 1'b0, 8'h21, 2'b11, 1'b0); idle(2);
    // R6: full page from 254 wraps, then R8 terminate
    cyc(1'b1, 1'b0, 8'd254, 2'b11, 1'b0); idle(5);
    cyc(1'b0, 1'b1, 8'h00, 2'b00, 1'b0); idle(2);
    // R9: restart mid burst
    cyc(1'b1, 1'b0, 8'd3, 2'b10, 1'b0); idle(2);
    cyc(1'b1, 1'b0, 8'd40, 2'b00, 1'b0); idle(3);
    // R4 with a burst running: running burst unchanged
    cyc(1'b1, 1'b0, 8'd0, 2'b10, 1'b0); idle(2);
    cyc(1'b1, 1'b0, 8'd1, 2'b11, 1'b0); idle(8);
    // R8 on a fixed burst
    cyc(1'b1, 1'b0, 8'd16, 2'b10, 1'b1); idle(1);
    cyc(1'b0, 1'b1, 8'h00, 2'b00, 1'b0); idle(2);
    for (int n = 0; n < 5000; n++) begin
      s  = ($urandom % 10) == 0;
      t  = ($urandom % 30) == 0;
      c  = 8'($urandom);
      l  = 2'($urandom);
      il = 1'($urandom);
      if (l == 2'b11 && ($urandom % 3) != 0) begin
        il = 1'b0; c[0] = 1'b0;
      end
      cyc(s, t, c, l, il);
    end
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule